// File: doc/BRIEF.md
# Dual-Timer Capture/Compare Channel

One capture/compare channel that follows one of two external free-running timers. In capture modes, a qualified edge on the input pin copies the chosen timer's count into the channel register. In compare modes, the chosen timer's count is matched against that register. A match raises an interrupt request and, depending on the mode, drives an output pin.

Software reaches the channel through a 16-bit control word that four channels share. Each channel takes its own 4-bit slice of that word. Software can also write the channel register directly. When the mode is off, the register is plain storage. The timers, interrupt arbitration and paired-register compare schemes lie outside this block.

Top module: `ccu_chan`

## Requirements
- R1: After reset the control nibble and the channel register are zero, the output pin is low and the interrupt request is low.
- R2: A control write loads bits [4*SLOT+3 : 4*SLOT] of the word. Bit 3 of that nibble selects the timer: 0 for timer A, 1 for timer B. Bits 2:0 select the mode. In mode 000 the register only holds what software writes, and no interrupt is raised.
- R3: A match occurs in a cycle where the selected timer's count differs from its value in the previous cycle and equals the register. The resulting interrupt is a one-cycle pulse in the following cycle.
- R4: Mode 100 raises an interrupt on every match, including several in one timer period, and leaves the pin unchanged.
- R5: Mode 101 inverts the pin and raises an interrupt on every match.
- R6: Mode 110 raises an interrupt only on the first match after an overflow strobe of the selected timer. If an overflow and a match fall in the same cycle, the match counts as the first of the new period.
- R7: Mode 111 drives the pin high on a match and low on an overflow of the selected timer. A match wins over an overflow in the same cycle. It raises at most one interrupt per period. The unselected timer's overflow has no effect. Pin levels change only in modes 101 and 111.
- R8: Modes 001, 010 and 011 capture on a rising edge, a falling edge, or either edge of the input pin. The pin passes through two synchronizing flops. The register holds the selected count, and the interrupt pulses, after the third clock edge following the pin change.
- R9: A register write in the same cycle as a capture wins: the register takes the written value and the interrupt still pulses.
- R10: With HAS_PIN = 0 the pin stays low in every mode, while interrupts behave exactly as with a pin.
- R11: The count of the unselected timer never produces a match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tmr_a_cnt | input | CNT_W | Timer A count |
| tmr_a_ovf | input | 1 | Timer A overflow strobe |
| tmr_b_cnt | input | CNT_W | Timer B count |
| tmr_b_ovf | input | 1 | Timer B overflow strobe |
| pin_in | input | 1 | Asynchronous capture input |
| ctl_we | input | 1 | Control word write strobe |
| ctl_wdata | input | 16 | Shared control word |
| reg_we | input | 1 | Channel register write strobe |
| reg_wdata | input | CNT_W | Channel register write value |
| pin_out | output | 1 | Compare output level |
| irq | output | 1 | Interrupt request pulse |
| reg_rdata | output | CNT_W | Channel register value |

## Verification
The bench builds two channels with CNT_W = 16 that share every input. One uses SLOT = 2 with HAS_PIN = 1, and the other uses SLOT = 0 with HAS_PIN = 0. Each control write sets both slices of the word identically, so the two channels must give the same interrupts and register values. This lets one stimulus stream check the slice selection and the pinless variant against the pin-equipped channel.

// File: rtl/ccu_chan.sv
module ccu_chan #(
  parameter int CNT_W   = 16,
  parameter int SLOT    = 0,
  parameter bit HAS_PIN = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] tmr_a_cnt,
  input  logic             tmr_a_ovf,
  input  logic [CNT_W-1:0] tmr_b_cnt,
  input  logic             tmr_b_ovf,
  input  logic             pin_in,
  input  logic             ctl_we,
  input  logic [15:0]      ctl_wdata,
  input  logic             reg_we,
  input  logic [CNT_W-1:0] reg_wdata,
  output logic             pin_out,
  output logic             irq,
  output logic [CNT_W-1:0] reg_rdata
);
  localparam int LSB = SLOT * 4;

  logic [3:0]       ctl;
  logic [CNT_W-1:0] cc, a_prev, b_prev;
  logic [2:0]       sync;
  logic             fired;

  wire [2:0]       mode     = ctl[2:0];
  wire             use_b    = ctl[3];
  wire [CNT_W-1:0] cnt_sel  = use_b ? tmr_b_cnt : tmr_a_cnt;
  wire [CNT_W-1:0] prev_sel = use_b ? b_prev : a_prev;
  wire             ovf_sel  = use_b ? tmr_b_ovf : tmr_a_ovf;

  wire hit       = (cnt_sel != prev_sel) && (cnt_sel == cc);
  wire once      = mode[2] & mode[1];
  wire fired_eff = fired & ~ovf_sel;
  wire fire      = mode[2] && hit && !(once && fired_eff);

  wire rise = sync[1] & ~sync[2];
  wire fall = ~sync[1] & sync[2];
  wire cap  = (mode == 3'b001 && rise) || (mode == 3'b010 && fall) ||
              (mode == 3'b011 && (rise || fall));

  assign reg_rdata = cc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl    <= '0;
      cc     <= '0;
      a_prev <= '0;
      b_prev <= '0;
      sync   <= '0;
      fired  <= 1'b0;
      irq    <= 1'b0;
    end else begin
      if (ctl_we) ctl <= ctl_wdata[LSB +: 4];
      if (reg_we)   cc <= reg_wdata;
      else if (cap) cc <= cnt_sel;
      a_prev <= tmr_a_cnt;
      b_prev <= tmr_b_cnt;
      sync   <= {sync[1:0], pin_in};
      fired  <= once ? (fired_eff | hit) : fired_eff;
      irq    <= fire | cap;
    end
  end

  generate
    if (HAS_PIN) begin : g_pin
      logic pin_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                        pin_q <= 1'b0;
        else if (mode == 3'b101 && hit)    pin_q <= ~pin_q;
        else if (mode == 3'b111 && hit)    pin_q <= 1'b1;
        else if (mode == 3'b111 && ovf_sel) pin_q <= 1'b0;
      end
      assign pin_out = pin_q;
    end else begin : g_nopin
      assign pin_out = 1'b0;
    end
  endgenerate
endmodule

module ccu_chan_chk #(
  parameter int CNT_W   = 16,
  parameter bit HAS_PIN = 1'b1
) (
  input logic             clk,
  input logic             rst_n,
  input logic [2:0]       mode,
  input logic             ovf_sel,
  input logic             hit,
  input logic             irq,
  input logic             pin_out,
  input logic             reg_we,
  input logic [CNT_W-1:0] reg_wdata,
  input logic [CNT_W-1:0] reg_rdata
);
  AST_NOPIN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !HAS_PIN |-> !pin_out); // R10
  AST_OFF_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    mode == 3'b000 |=> !irq); // R2
  AST_OFF_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'b000 && !reg_we) |=> $stable(reg_rdata)); // R2
  AST_PIN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != 3'b101 && mode != 3'b111) |=> $stable(pin_out)); // R7
  AST_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (HAS_PIN && mode == 3'b101 && hit) |=> pin_out != $past(pin_out)); // R5
  AST_OVF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'b111 && ovf_sel && !hit) |=> !pin_out); // R7
  AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |=> reg_rdata == $past(reg_wdata)); // R9
endmodule

bind ccu_chan ccu_chan_chk #(.CNT_W(CNT_W), .HAS_PIN(HAS_PIN)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode(mode), .ovf_sel(ovf_sel), .hit(hit),
  .irq(irq), .pin_out(pin_out), .reg_we(reg_we), .reg_wdata(reg_wdata),
  .reg_rdata(reg_rdata)
);

// File: tb/ccu_chan_bench.sv
`timescale 1ns/1ps
module ccu_chan_bench;
  logic clk = 0, rst_n = 0;
  logic [15:0] ta = 0, tb = 0, ctl_wdata = 0, reg_wdata = 0;
  logic aovf = 0, bovf = 0, pin_in = 0, ctl_we = 0, reg_we = 0;
  logic pin1, irq1, pin2, irq2;
  logic [15:0] rd1, rd2;
  int tests = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  ccu_chan #(.CNT_W(16), .SLOT(2), .HAS_PIN(1'b1)) u_ccu_chan (
    .clk(clk), .rst_n(rst_n), .tmr_a_cnt(ta), .tmr_a_ovf(aovf),
    .tmr_b_cnt(tb), .tmr_b_ovf(bovf), .pin_in(pin_in), .ctl_we(ctl_we),
    .ctl_wdata(ctl_wdata), .reg_we(reg_we), .reg_wdata(reg_wdata),
    .pin_out(pin1), .irq(irq1), .reg_rdata(rd1));

  ccu_chan #(.CNT_W(16), .SLOT(0), .HAS_PIN(1'b0)) u_ccu_chan_nopin (
    .clk(clk), .rst_n(rst_n), .tmr_a_cnt(ta), .tmr_a_ovf(aovf),
    .tmr_b_cnt(tb), .tmr_b_ovf(bovf), .pin_in(pin_in), .ctl_we(ctl_we),
    .ctl_wdata(ctl_wdata), .reg_we(reg_we), .reg_wdata(reg_wdata),
    .pin_out(pin2), .irq(irq2), .reg_rdata(rd2));

  typedef struct {
    logic        irq;
    logic        pin;
    logic [15:0] rd;
    string       tag;
  } exp_t;
  exp_t q[$];
  exp_t e;

  always @(posedge clk) begin
    #1;
    if (q.size() > 0) begin
      e = q.pop_front();
      tests++;
      if (irq1 !== e.irq || pin1 !== e.pin || rd1 !== e.rd ||
          irq2 !== e.irq || pin2 !== 1'b0 || rd2 !== e.rd) begin
        fails++;
        $display("FAIL %s: irq=%b/%b pin=%b/%b rd=%h/%h, expected irq=%b pin=%b/0 rd=%h",
                 e.tag, irq1, irq2, pin1, pin2, rd1, rd2, e.irq, e.pin, e.rd);
      end
    end
  end

  task automatic tick(input logic ei, input logic ep, input logic [15:0] er, input string t);
    q.push_back('{irq: ei, pin: ep, rd: er, tag: t});
    @(negedge clk);
    ctl_we = 0; reg_we = 0; aovf = 0; bovf = 0;
  endtask

  task automatic ctl(input logic [15:0] w, input logic ep, input logic [15:0] er, input string t);
    ctl_we = 1; ctl_wdata = w;
    tick(0, ep, er, t);
  endtask

  initial begin
    #200000;
    if (!done) begin
      done = 1; fails++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    tick(0, 0, 16'h0000, "R1 reset");
    // storage mode
    reg_we = 1; reg_wdata = 16'h1234; ta = 16'h0005;
    tick(0, 0, 16'h1234, "R2 storage write");
    ta = 16'h1234; tick(0, 0, 16'h1234, "R2 mode off no irq");
    // mode 100 on timer A
    ctl(16'h0404, 0, 16'h1234, "R3 no advance no match");
    ta = 16'h1233; tick(0, 0, 16'h1234, "R3 no match");
    ta = 16'h1234; tick(1, 0, 16'h1234, "R4 match irq");
    tick(0, 0, 16'h1234, "R3 held count no match");
    ta = 16'h1233; tick(0, 0, 16'h1234, "R4 miss");
    ta = 16'h1234; tick(1, 0, 16'h1234, "R4 second match same period");
    tb = 16'h1234; tick(0, 0, 16'h1234, "R11 other timer ignored");
    // mode 101 on timer B
    ctl(16'h0D0D, 0, 16'h1234, "R5 select");
    tb = 16'h0000; tick(0, 0, 16'h1234, "R5 miss");
    tb = 16'h1234; tick(1, 1, 16'h1234, "R5 toggle high");
    tb = 16'h1235; tick(0, 1, 16'h1234, "R5 hold");
    tb = 16'h1234; tick(1, 0, 16'h1234, "R5 toggle low");
    ta = 16'h0000; tick(0, 0, 16'h1234, "R11 timer A ignored");
    // mode 110 on timer A
    ctl(16'h0606, 0, 16'h1234, "R6 select");
    ta = 16'h1233; tick(0, 0, 16'h1234, "R6 miss");
    ta = 16'h1234; tick(1, 0, 16'h1234, "R6 first match");
    ta = 16'h1233; tick(0, 0, 16'h1234, "R6 miss");
    ta = 16'h1234; tick(0, 0, 16'h1234, "R6 second match suppressed");
    bovf = 1; tb = 16'h0001; tick(0, 0, 16'h1234, "R6 other overflow");
    ta = 16'h1233; tick(0, 0, 16'h1234, "R6 miss");
    ta = 16'h1234; tick(0, 0, 16'h1234, "R6 still suppressed");
    ta = 16'h0000; aovf = 1; tick(0, 0, 16'h1234, "R6 overflow");
    ta = 16'h1234; tick(1, 0, 16'h1234, "R6 new period match");
    // mode 111 on timer A
    ctl(16'h0707, 0, 16'h1234, "R7 select");
    ta = 16'h0000; aovf = 1; tick(0, 0, 16'h1234, "R7 overflow");
    ta = 16'h1234; tick(1, 1, 16'h1234, "R7 set on match");
    ta = 16'h1233; tick(0, 1, 16'h1234, "R7 hold");
    ta = 16'h1234; tick(0, 1, 16'h1234, "R7 one irq per period");
    tb = 16'h0005; bovf = 1; tick(0, 1, 16'h1234, "R7 other overflow ignored");
    ta = 16'h0000; aovf = 1; tick(0, 0, 16'h1234, "R7 clear on overflow");
    ta = 16'h1234; tick(1, 1, 16'h1234, "R7 set again");
    ta = 16'h1233; tick(0, 1, 16'h1234, "R7 hold");
    ta = 16'h1234; aovf = 1; tick(1, 1, 16'h1234, "R7 overflow with match");
    // capture rising, timer B
    tb = 16'h0777;
    ctl(16'h0909, 1, 16'h1234, "R8 select rise");
    pin_in = 1; tick(0, 1, 16'h1234, "R8 sync 1");
    tick(0, 1, 16'h1234, "R8 sync 2");
    tick(1, 1, 16'h0777, "R8 rise capture");
    tb = 16'h0888; pin_in = 0; tick(0, 1, 16'h0777, "R8 fall 1");
    tick(0, 1, 16'h0777, "R8 fall 2");
    tick(0, 1, 16'h0777, "R8 fall ignored");
    // capture falling
    ctl(16'h0A0A, 1, 16'h0777, "R8 select fall");
    pin_in = 1; tick(0, 1, 16'h0777, "R8 rise 1");
    tick(0, 1, 16'h0777, "R8 rise 2");
    tick(0, 1, 16'h0777, "R8 rise ignored");
    tb = 16'h0999; pin_in = 0; tick(0, 1, 16'h0777, "R8 sync 1");
    tick(0, 1, 16'h0777, "R8 sync 2");
    tick(1, 1, 16'h0999, "R8 fall capture");
    // capture both, write priority
    ctl(16'h0B0B, 1, 16'h0999, "R8 select both");
    tb = 16'h0AAA; pin_in = 1; tick(0, 1, 16'h0999, "R9 sync 1");
    tick(0, 1, 16'h0999, "R9 sync 2");
    reg_we = 1; reg_wdata = 16'hBEEF; tick(1, 1, 16'hBEEF, "R9 write beats capture");
    tb = 16'h0ABC; pin_in = 0; tick(0, 1, 16'hBEEF, "R8 sync 1");
    tick(0, 1, 16'hBEEF, "R8 sync 2");
    tick(1, 1, 16'h0ABC, "R8 both-edge capture R10");
    @(negedge clk); @(negedge clk);
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule